// File: doc/BRIEF.md
# Victim-Retention Cache Replacement Controller

This block holds the tags, valid bits and replacement state of a small set-associative cache that has four sets of eight ways. Six ways of each set are private to that set. The other two ways of every set are pooled into one shared reserve of eight entries, and any set may place lines there. Private ways keep no recency information. When a private way has to be reused, its current line is not dropped: it moves into the reserve pool. The pool is the only place where lines are finally evicted, and it evicts in true least-recently-used order. Heavily used sets can therefore borrow capacity from quiet ones, and true LRU is paid for only on the pool.

The request side is one address (a line address with no byte offset) qualified by a valid strobe. A request can be issued on any cycle. A registered response follows one cycle later. It says whether the line hit, whether it was found in a private way or in the pool, which private way now holds it, which pool entry matched, and which line, if any, was pushed out of the cache for good. Data arrays are not modelled. At reset the pool's age order runs from entry 0 (oldest) to entry 7 (newest).

Top module: `vr_cache_ctrl`

## Requirements
- R1: The address is a 12-bit line address. The set index is bits [1:0] and the tag is bits [11:2]. A request hits when its tag is valid in one of its set's six private ways, or when its whole address is valid in one of the eight pool entries. rsp_loc reports 0 for a miss, 1 for a private hit and 2 for a pool hit, and rsp_hit is 1 exactly when rsp_loc is not 0.
- R2: rsp_valid is 1 in the cycle after a cycle with req_valid high, and 0 after a cycle without a request.
- R3: A private hit reports the matching way in rsp_way, changes no stored state and evicts nothing.
- R4: On a miss or a pool hit, the requested line is written into a private way of its set. The way is the lowest-index invalid way if one exists. Otherwise it is the value of a free-running pseudo-random sequence reduced to the range 0..5. rsp_way reports the way written.
- R5: A valid private line that is displaced by R4 is moved into the pool, not discarded, and a later request for it hits in the pool.
- R6: A line moved into the pool after a miss goes to the lowest-index invalid pool entry, or to the least-recently-used entry if none is invalid. That entry becomes most recently used.
- R7: On a pool hit at entry e, rsp_entry reports e. The line displaced from the private ways (if any) takes entry e, otherwise entry e becomes invalid, and entry e becomes most recently used.
- R8: rsp_evict_valid is 1, with rsp_evict_addr set to the address of the pool's least-recently-used line, only when a miss pushes a valid private line into a pool with no invalid entry. It is 0 on every hit. An evicted line misses afterwards.
- R9: Pool entries are shared. Displaced lines from different sets occupy entries side by side, and each one hits from its own set.
- R10: Reset clears every private and pool valid bit and sets the pool age order to entry index order, with entry 0 oldest.
- R11: The pool ages always form a strict order with exactly one least-recently-used entry, so every eviction is unambiguous.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 12 | Line address of the request |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_hit | output | 1 | Line was present |
| rsp_loc | output | 2 | 0 miss, 1 private hit, 2 pool hit |
| rsp_way | output | 3 | Private way now holding the requested line |
| rsp_entry | output | 3 | Pool entry matched on a pool hit |
| rsp_evict_valid | output | 1 | A line left the cache |
| rsp_evict_addr | output | 12 | Line address that left the cache |

## Verification
On every cycle, the assertions check the response timing, that rsp_hit agrees with rsp_loc, that evictions happen only on misses and only when the pool is full, that the pool ages keep exactly one oldest entry, and the state just after reset. The rest can only be shown by the bench's scenarios. These are the choice of fill way, the movement of displaced lines into the pool and back, the LRU order across many inserts, which address is evicted, and the sharing of the pool between sets. A shadow model follows the design over directed sequences and a stream biased toward two hot sets.

// File: rtl/vr_pkg.sv
package vr_pkg;
    localparam int ADDR_W  = 12;
    localparam int SETS    = 4;
    localparam int WAYS    = 8;
    localparam int RSV     = 2;
    localparam int LFSR_W  = 8;
    localparam logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8;

    localparam int PRIV    = WAYS - RSV;
    localparam int POOL    = SETS * RSV;
    localparam int SET_W   = $clog2(SETS);
    localparam int TAG_W   = ADDR_W - SET_W;
    localparam int WAY_W   = $clog2(PRIV);
    localparam int POOL_W  = $clog2(POOL);

    typedef enum logic [1:0] {
        LOC_MISS = 2'd0,
        LOC_PRIV = 2'd1,
        LOC_POOL = 2'd2
    } loc_e;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
    } line_t;

    typedef struct packed {
        logic              valid;
        logic              hit;
        loc_e              loc;
        logic [WAY_W-1:0]  way;
        logic [POOL_W-1:0] entry;
        logic              ev_vld;
        logic [ADDR_W-1:0] ev_addr;
    } rsp_t;

    function automatic logic [SET_W-1:0] set_of(input logic [ADDR_W-1:0] a);
        return a[SET_W-1:0];
    endfunction

    function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:SET_W];
    endfunction
endpackage

// File: rtl/vr_lfsr.sv
module vr_lfsr import vr_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    output logic [LFSR_W-1:0] state
);
    logic fb;
    assign fb = ^(state & LFSR_TAPS);

    always_ff @(posedge clk) begin
        if (rst) state <= LFSR_W'(1);
        else     state <= {state[LFSR_W-2:0], fb};
    end
endmodule

// File: rtl/vr_priv_array.sv
module vr_priv_array import vr_pkg::*; (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [SET_W-1:0]           rd_set,
    input  logic [TAG_W-1:0]           rd_tag,
    output logic [PRIV-1:0]            hit_vec,
    output logic [PRIV-1:0]            vld_vec,
    output logic [PRIV-1:0][TAG_W-1:0] tag_vec,
    input  logic                       wr_en,
    input  logic [SET_W-1:0]           wr_set,
    input  logic [WAY_W-1:0]           wr_way,
    input  logic [TAG_W-1:0]           wr_tag,
    output logic [SETS*PRIV-1:0]       vld_all
);
    logic [TAG_W-1:0] tag_flat [SETS*PRIV];

    for (genvar s = 0; s < SETS; s++) begin : g_set
        for (genvar w = 0; w < PRIV; w++) begin : g_way
            logic             v_q;
            logic [TAG_W-1:0] t_q;
            logic             sel;
            assign sel = wr_en && (wr_set == SET_W'(s)) && (wr_way == WAY_W'(w));

            always_ff @(posedge clk) begin
                if (rst)      v_q <= 1'b0;
                else if (sel) v_q <= 1'b1;
            end

            always_ff @(posedge clk) begin
                if (sel) t_q <= wr_tag;
            end

            assign vld_all[s*PRIV + w]  = v_q;
            assign tag_flat[s*PRIV + w] = t_q;
        end
    end

    always_comb begin
        for (int w = 0; w < PRIV; w++) begin
            vld_vec[w] = vld_all[int'(rd_set)*PRIV + w];
            tag_vec[w] = tag_flat[int'(rd_set)*PRIV + w];
            hit_vec[w] = vld_vec[w] && (tag_vec[w] == rd_tag);
        end
    end
endmodule

// File: rtl/vr_pool.sv
module vr_pool import vr_pkg::*; (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [ADDR_W-1:0]      lk_addr,
    output logic [POOL-1:0]        hit_vec,
    output logic [POOL-1:0]        vld_vec,
    output logic [POOL_W-1:0]      ins_idx,
    output line_t                  ins_old,
    input  logic                   wr_en,
    input  logic [POOL_W-1:0]      wr_idx,
    input  line_t                  wr_line,
    output logic [POOL*POOL_W-1:0] age_flat
);
    logic [POOL-1:0]   vld_q;
    logic [ADDR_W-1:0] addr_q [POOL];
    logic [POOL_W-1:0] age_q  [POOL];
    logic [POOL_W-1:0] lru_idx;
    logic              free_found;

    always_ff @(posedge clk) begin
        if (rst)        vld_q <= '0;
        else if (wr_en) vld_q[wr_idx] <= wr_line.vld;
    end

    always_ff @(posedge clk) begin
        if (wr_en) addr_q[wr_idx] <= wr_line.addr;
    end

    // Age 0 is most recent, POOL-1 is least recent; a touch promotes one entry.
    always_ff @(posedge clk) begin
        for (int i = 0; i < POOL; i++) begin
            if (rst)
                age_q[i] <= POOL_W'(POOL - 1 - i);
            else if (wr_en) begin
                if (POOL_W'(i) == wr_idx)          age_q[i] <= '0;
                else if (age_q[i] < age_q[wr_idx]) age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

    for (genvar i = 0; i < POOL; i++) begin : g_cmp
        assign hit_vec[i] = vld_q[i] && (addr_q[i] == lk_addr);
        assign age_flat[i*POOL_W +: POOL_W] = age_q[i];
    end

    assign vld_vec = vld_q;

    always_comb begin
        lru_idx = '0;
        for (int i = 0; i < POOL; i++)
            if (age_q[i] == POOL_W'(POOL - 1)) lru_idx = POOL_W'(i);
        free_found = 1'b0;
        ins_idx    = lru_idx;
        for (int i = 0; i < POOL; i++) begin
            if (!vld_q[i] && !free_found) begin
                ins_idx    = POOL_W'(i);
                free_found = 1'b1;
            end
        end
        ins_old.vld  = vld_q[ins_idx];
        ins_old.addr = addr_q[ins_idx];
    end
endmodule

// File: rtl/vr_cache_ctrl.sv
module vr_cache_ctrl import vr_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [1:0]        rsp_loc,
    output logic [WAY_W-1:0]  rsp_way,
    output logic [POOL_W-1:0] rsp_entry,
    output logic              rsp_evict_valid,
    output logic [ADDR_W-1:0] rsp_evict_addr
);
    logic [SET_W-1:0]           req_set;
    logic [TAG_W-1:0]           req_tag;
    logic [PRIV-1:0]            phit;
    logic [PRIV-1:0]            pvld;
    logic [PRIV-1:0][TAG_W-1:0] ptag;
    logic [SETS*PRIV-1:0]       priv_vld_all;
    logic [POOL-1:0]            qhit;
    logic [POOL-1:0]            pool_vld;
    logic [POOL*POOL_W-1:0]     age_flat;
    logic [POOL_W-1:0]          ins_idx;
    line_t                      ins_old;
    logic [LFSR_W-1:0]          lfsr_q;

    logic              priv_hit, pool_hit, inv_found;
    logic [WAY_W-1:0]  phit_way, victim, rand_way;
    logic [POOL_W-1:0] qhit_idx;
    line_t             vict_line;
    logic              priv_we, pool_we;
    logic [POOL_W-1:0] pool_widx;
    rsp_t              rsp_d, rsp_q;

    assign req_set = set_of(req_addr);
    assign req_tag = tag_of(req_addr);

    vr_lfsr u_lfsr (.clk(clk), .rst(rst), .state(lfsr_q));

    vr_priv_array u_priv (
        .clk(clk), .rst(rst),
        .rd_set(req_set), .rd_tag(req_tag),
        .hit_vec(phit), .vld_vec(pvld), .tag_vec(ptag),
        .wr_en(priv_we), .wr_set(req_set), .wr_way(victim), .wr_tag(req_tag),
        .vld_all(priv_vld_all)
    );

    vr_pool u_pool (
        .clk(clk), .rst(rst),
        .lk_addr(req_addr),
        .hit_vec(qhit), .vld_vec(pool_vld),
        .ins_idx(ins_idx), .ins_old(ins_old),
        .wr_en(pool_we), .wr_idx(pool_widx), .wr_line(vict_line),
        .age_flat(age_flat)
    );

    assign rand_way = WAY_W'(lfsr_q % LFSR_W'(PRIV));

    always_comb begin
        phit_way = '0;
        for (int w = 0; w < PRIV; w++)
            if (phit[w]) phit_way = WAY_W'(w);
        qhit_idx = '0;
        for (int i = 0; i < POOL; i++)
            if (qhit[i]) qhit_idx = POOL_W'(i);
        inv_found = 1'b0;
        victim    = rand_way;
        for (int w = 0; w < PRIV; w++) begin
            if (!pvld[w] && !inv_found) begin
                victim    = WAY_W'(w);
                inv_found = 1'b1;
            end
        end
    end

    assign priv_hit       = |phit;
    assign pool_hit       = (|qhit) && !priv_hit;
    assign vict_line.vld  = pvld[victim];
    assign vict_line.addr = {ptag[victim], req_set};

    assign priv_we   = req_valid && !priv_hit;
    assign pool_we   = req_valid && (pool_hit || (!priv_hit && vict_line.vld));
    assign pool_widx = pool_hit ? qhit_idx : ins_idx;

    always_comb begin
        rsp_d         = '0;
        rsp_d.valid   = req_valid;
        rsp_d.hit     = req_valid && (priv_hit || pool_hit);
        rsp_d.loc     = !req_valid ? LOC_MISS :
                        priv_hit   ? LOC_PRIV :
                        pool_hit   ? LOC_POOL : LOC_MISS;
        rsp_d.way     = priv_hit ? phit_way : victim;
        rsp_d.entry   = qhit_idx;
        rsp_d.ev_vld  = req_valid && !priv_hit && !pool_hit && vict_line.vld && ins_old.vld;
        rsp_d.ev_addr = ins_old.addr;
    end

    always_ff @(posedge clk) begin
        if (rst) rsp_q <= '0;
        else     rsp_q <= rsp_d;
    end

    assign rsp_valid       = rsp_q.valid;
    assign rsp_hit         = rsp_q.hit;
    assign rsp_loc         = rsp_q.loc;
    assign rsp_way         = rsp_q.way;
    assign rsp_entry       = rsp_q.entry;
    assign rsp_evict_valid = rsp_q.ev_vld;
    assign rsp_evict_addr  = rsp_q.ev_addr;
endmodule

// File: rtl/vr_ctrl_chk.sv
module vr_ctrl_chk import vr_pkg::*; (
    input logic                   clk,
    input logic                   rst,
    input logic                   req_valid,
    input logic                   rsp_valid,
    input logic                   rsp_hit,
    input logic [1:0]             rsp_loc,
    input logic                   rsp_evict_valid,
    input logic [POOL-1:0]        pool_vld,
    input logic [SETS*PRIV-1:0]   priv_vld_all,
    input logic [POOL*POOL_W-1:0] age_flat
);
    logic [POOL-1:0] is_lru;
    logic            rst_d;

    always_comb
        for (int i = 0; i < POOL; i++)
            is_lru[i] = (age_flat[i*POOL_W +: POOL_W] == POOL_W'(POOL - 1));

    always_ff @(posedge clk) rst_d <= rst;

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid) else $error("rsp missing");                     // R2
    AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid) else $error("rsp without request");           // R2
    AST_HIT_MATCHES_LOC: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_hit == (rsp_loc != 2'd0))) else $error("hit/loc");   // R1
    AST_EVICT_ON_MISS: assert property (@(posedge clk) disable iff (rst)
        rsp_evict_valid |-> (rsp_valid && !rsp_hit)) else $error("evict on hit"); // R8
    AST_EVICT_POOL_FULL: assert property (@(posedge clk) disable iff (rst)
        rsp_evict_valid |-> (&pool_vld)) else $error("evict with free entry");   // R8
    AST_ONE_LRU: assert property (@(posedge clk) disable iff (rst)
        $countones(is_lru) == 1) else $error("lru not unique");                 // R11

    always_ff @(posedge clk) begin
        if (rst_d && !rst) begin
            AST_RESET_CLEAR: assert (pool_vld == '0 && priv_vld_all == '0 && is_lru[0])
                else $error("reset state");                                     // R10
        end
    end
endmodule

bind vr_cache_ctrl vr_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_loc(rsp_loc),
    .rsp_evict_valid(rsp_evict_valid),
    .pool_vld(pool_vld), .priv_vld_all(priv_vld_all), .age_flat(age_flat)
);

// File: tb/vr_cache_ctrl_bench.sv
`timescale 1ns/1ps
module vr_cache_ctrl_bench;
    import vr_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              rsp_valid, rsp_hit, rsp_evict_valid;
    logic [1:0]        rsp_loc;
    logic [WAY_W-1:0]  rsp_way;
    logic [POOL_W-1:0] rsp_entry;
    logic [ADDR_W-1:0] rsp_evict_addr;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    vr_cache_ctrl u_vr_cache_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_loc(rsp_loc),
        .rsp_way(rsp_way), .rsp_entry(rsp_entry),
        .rsp_evict_valid(rsp_evict_valid), .rsp_evict_addr(rsp_evict_addr)
    );

    // Shadow model
    logic [TAG_W-1:0]  m_tag [SETS][PRIV];
    bit                m_v   [SETS][PRIV];
    logic [ADDR_W-1:0] m_pa  [POOL];
    bit                m_pv  [POOL];
    int                m_age [POOL];
    bit                last_disp_v;
    logic [ADDR_W-1:0] last_disp_a;
    int                n_evict, n_poolhit;

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] mk(input int s, input int t);
        return ADDR_W'((t << SET_W) | s);
    endfunction

    task automatic model_touch(input int e);
        int old = m_age[e];
        for (int i = 0; i < POOL; i++)
            if (i != e && m_age[i] < old) m_age[i]++;
        m_age[e] = 0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(rsp_valid == 1'b0, "R10", "rsp_valid in reset", rsp_valid, 0);
        rst = 1'b0;
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < PRIV; w++) m_v[s][w] = 1'b0;
        for (int i = 0; i < POOL; i++) begin
            m_pv[i]  = 1'b0;
            m_age[i] = POOL - 1 - i;
        end
    endtask

    task automatic access(input logic [ADDR_W-1:0] a, output int loc_o);
        int s = int'(a[SET_W-1:0]);
        logic [TAG_W-1:0] t = a[ADDR_W-1:SET_W];
        int eloc = 0, eway = 0, eent = 0, fi = -1, w, idx;
        bit dv;
        logic [ADDR_W-1:0] da;
        for (int k = 0; k < PRIV; k++)
            if (m_v[s][k] && m_tag[s][k] == t) begin eloc = 1; eway = k; end
        if (eloc == 0)
            for (int e = 0; e < POOL; e++)
                if (m_pv[e] && m_pa[e] == a) begin eloc = 2; eent = e; end
        for (int k = PRIV - 1; k >= 0; k--)
            if (!m_v[s][k]) fi = k;

        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;

        chk(rsp_valid == 1'b1, "R2", "rsp_valid", rsp_valid, 1);
        chk(rsp_loc == 2'(eloc), "R1", "rsp_loc", rsp_loc, eloc);
        chk(rsp_hit == (eloc != 0), "R1", "rsp_hit", rsp_hit, eloc != 0);
        last_disp_v = 1'b0;
        last_disp_a = '0;
        if (eloc == 1) begin
            chk(rsp_way == WAY_W'(eway), "R3", "hit way", rsp_way, eway);
            chk(rsp_evict_valid == 1'b0, "R3", "evict on private hit", rsp_evict_valid, 0);
        end else begin
            w = int'(rsp_way);
            if (fi >= 0) chk(w == fi, "R4", "fill way (lowest invalid)", w, fi);
            else         chk(w < PRIV, "R4", "fill way range", w, PRIV - 1);
            if (w >= PRIV) w = 0;
            dv = m_v[s][w];
            da = {m_tag[s][w], SET_W'(s)};
            m_v[s][w]   = 1'b1;
            m_tag[s][w] = t;
            last_disp_v = dv;
            last_disp_a = da;
            if (eloc == 2) begin
                n_poolhit++;
                chk(rsp_entry == POOL_W'(eent), "R7", "pool hit entry", rsp_entry, eent);
                chk(rsp_evict_valid == 1'b0, "R8", "evict on pool hit", rsp_evict_valid, 0);
                m_pv[eent] = dv;
                m_pa[eent] = da;
                model_touch(eent);
            end else if (dv) begin
                idx = -1;
                for (int e = POOL - 1; e >= 0; e--) if (!m_pv[e]) idx = e;
                if (idx < 0)
                    for (int e = 0; e < POOL; e++) if (m_age[e] == POOL - 1) idx = e;
                chk(rsp_evict_valid == m_pv[idx], "R8", "evict flag", rsp_evict_valid, m_pv[idx]);
                if (m_pv[idx]) begin
                    n_evict++;
                    chk(rsp_evict_addr == m_pa[idx], "R11", "LRU evict address",
                        rsp_evict_addr, m_pa[idx]);
                end
                m_pv[idx] = 1'b1;
                m_pa[idx] = da;
                model_touch(idx);
            end else begin
                chk(rsp_evict_valid == 1'b0, "R8", "evict with no displaced line",
                    rsp_evict_valid, 0);
            end
        end
        loc_o = eloc;
    endtask

    task automatic t_reset();
        int l;
        do_reset();
        access(mk(1, 5), l);
        chk(l == 0 && rsp_way == '0 && !rsp_evict_valid, "R10", "first access after reset",
            {rsp_evict_valid, rsp_way}, 0);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R2", "rsp_valid on idle cycle", rsp_valid, 0);
    endtask

    task automatic t_private_hit();
        int l;
        do_reset();
        for (int k = 1; k <= PRIV; k++) access(mk(0, k), l);
        access(mk(0, 3), l);
        chk(l == 1 && rsp_way == 3'd2, "R3", "private hit way", rsp_way, 2);
        access(mk(0, 3), l);
        chk(l == 1, "R3", "private hit repeat", l, 1);
        for (int k = 1; k <= PRIV; k++) begin
            access(mk(0, k), l);
            chk(l == 1, "R3", "private lines unchanged", l, 1);
        end
    endtask

    task automatic t_spill();
        int l;
        logic [ADDR_W-1:0] d;
        do_reset();
        for (int k = 1; k <= PRIV + 1; k++) access(mk(0, k), l);
        chk(last_disp_v == 1'b1, "R5", "line displaced", last_disp_v, 1);
        d = last_disp_a;
        access(d, l);
        chk(l == 2, "R5", "displaced line hits in pool", l, 2);
        chk(rsp_entry == '0, "R6", "first spill in entry 0", rsp_entry, 0);
        d = last_disp_a;
        access(d, l);
        chk(l == 2 && rsp_entry == '0, "R7", "swapped line back in entry", rsp_entry, 0);
    endtask

    task automatic t_pool_full();
        int l;
        logic [ADDR_W-1:0] first;
        do_reset();
        for (int k = 1; k <= PRIV + POOL; k++) begin
            access(mk(0, k), l);
            if (k == PRIV + 1) first = last_disp_a;
            chk(rsp_evict_valid == 1'b0, "R8", "no evict while pool fills", rsp_evict_valid, 0);
        end
        access(mk(0, PRIV + POOL + 1), l);
        chk(rsp_evict_valid == 1'b1, "R8", "evict when pool full", rsp_evict_valid, 1);
        chk(rsp_evict_addr == first, "R8", "oldest spill evicted", rsp_evict_addr, first);
        access(first, l);
        chk(l == 0, "R8", "evicted line misses", l, 0);
    endtask

    task automatic t_shared();
        int l;
        logic [ADDR_W-1:0] s2first;
        do_reset();
        for (int k = 1; k <= PRIV + 3; k++) access(mk(1, k), l);
        for (int k = 1; k <= PRIV + 2; k++) begin
            access(mk(2, k), l);
            if (k == PRIV + 1) s2first = last_disp_a;
        end
        access(s2first, l);
        chk(l == 2 && rsp_entry == 3'd3, "R9", "set 2 line in shared entry 3", rsp_entry, 3);
    endtask

    task automatic t_random();
        int l;
        logic [ADDR_W-1:0] a;
        do_reset();
        n_evict   = 0;
        n_poolhit = 0;
        for (int n = 0; n < 3000; n++) begin
            if (($urandom % 10) < 8) a = mk($urandom % 2, $urandom % 12);
            else                     a = ADDR_W'($urandom);
            access(a, l);
        end
        chk(n_evict > 0, "R11", "evictions seen in stream", n_evict, 1);
        chk(n_poolhit > 0, "R5", "pool hits seen in stream", n_poolhit, 1);
    endtask

    initial begin
        #(5.0 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        n_evict   = 0;
        n_poolhit = 0;
        t_reset();
        t_private_hit();
        t_spill();
        t_pool_full();
        t_shared();
        t_random();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule